// File: doc/BRIEF.md
# Two-Stage Sequenced Event Trigger

This block watches two qualified condition flags, A and B, one sample per clock, and raises a trigger once an ordered sequence of the two has been seen. A chosen transition of A opens the sequence. In counted mode the trigger comes on a programmed number of B transitions. In delayed mode it comes on the first B transition that arrives after a programmed number of cycles has passed since A. After each trigger, a hold-off interval blocks every event before the block goes back to waiting for A.

The condition flags come from comparators or pattern logic outside the block. For each of A and B, a select picks whether the rising transition (entering the condition) or the falling transition (leaving it) counts as an event. The occurrence count, the delay and the hold-off are all plain cycle counts. A synchronous clear input can restart the sequence at any time. The asynchronous reset is released through an internal two-stage synchronizer.

Top module: `seq_trigger`

## Requirements
- R1: With its select at 0, a condition counts as an event in the cycle its flag is 1 after being 0 in the previous cycle. With its select at 1, it counts in the cycle its flag is 0 after being 1. The previous value is taken as 0 after reset.
- R2: With `mode_delay`=0, the trigger fires on the Nth B event that follows the A event. N is `count_n`, and `count_n`=0 acts as 1. A B event in the same cycle as the A event is not counted.
- R3: B events are ignored while the block waits for A. A events are ignored while a sequence is running, so they neither restart nor reset the count.
- R4: With `mode_delay`=1, let the A event fall in cycle t. A B event in cycle t+k fires the trigger only if k > `delay_cycles`, and the first such B event fires it. B events with k <= `delay_cycles` have no effect.
- R5: `trig` is registered. It is 1 for exactly one cycle, in the cycle that follows the qualifying B event.
- R6: Let a trigger fire on the B event of cycle f, with H = `holdoff_cycles`. Every event in cycles f+1 to f+H is ignored, including A events. An A event in cycle f+H+1 starts a new sequence.
- R7: `arm_clr`=1 returns the block to waiting for A in the next cycle. It also blocks a trigger that would have fired in that same cycle.
- R8: After reset, `trig` is 0 and the block waits for A.
- R9: The mode is taken from `mode_delay` in the cycle the A event is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_clr | input | 1 | Synchronous sequence restart |
| cond_a | input | 1 | Condition A flag |
| cond_b | input | 1 | Condition B flag |
| mode_delay | input | 1 | 0 counted, 1 delayed |
| a_on_exit | input | 1 | A event on the falling transition when 1 |
| b_on_exit | input | 1 | B event on the falling transition when 1 |
| count_n | input | 27 | B occurrence count for counted mode |
| delay_cycles | input | 32 | Minimum gap after A, in cycles |
| holdoff_cycles | input | 32 | Blocked cycles after a trigger |
| trig | output | 1 | One-cycle trigger pulse |

## Verification
The hardest situations to reach are the exact edges of the two timed windows: a B event one cycle before the delay has run out versus one cycle after, and an A event in the last hold-off cycle versus the first free one. The stimulus sets both windows to small values. It then places B and A transitions cycle by cycle relative to the observed trigger, so each window edge is hit on both sides. A long counted run with a count of one thousand shows that no trigger fires early once the counter is wide.

// File: rtl/seq_trig_pkg.sv
package seq_trig_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_A = 2'd0,
    ST_COUNT  = 2'd1,
    ST_DELAY  = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/seq_edge_sel.sv
module seq_edge_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic flag,
  input  logic on_exit,
  output logic evt
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= flag;
  end

  assign evt = on_exit ? (prev_q & ~flag) : (~prev_q & flag);
endmodule

// File: rtl/seq_span_timer.sv
module seq_span_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)                 cnt_d = '0;
    else if (en && ~&cnt)    cnt_d = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/seq_core.sv
module seq_core
  import seq_trig_pkg::*;
#(
  parameter int CNT_W  = 27,
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_clr,
  input  logic              ev_a,
  input  logic              ev_b,
  input  logic              mode_delay,
  input  logic [CNT_W-1:0]  count_n,
  input  logic [TIME_W-1:0] delay_cycles,
  input  logic [TIME_W-1:0] holdoff_cycles,
  input  logic [TIME_W-1:0] tcnt,
  output logic              tmr_clr,
  output logic              tmr_en,
  output logic              fire,
  output seq_state_e        state
);
  localparam int CW1 = CNT_W + 1;
  localparam int TW1 = TIME_W + 1;

  seq_state_e       st_d;
  logic [CNT_W-1:0] occ_q, occ_d;
  logic [CW1-1:0]   occ_inc, n_eff;
  logic             elapsed, hold_done;

  assign occ_inc   = {1'b0, occ_q} + CW1'(1);
  assign n_eff     = (count_n == '0) ? CW1'(1) : {1'b0, count_n};
  assign elapsed   = tcnt >= delay_cycles;
  assign hold_done = ({1'b0, tcnt} + TW1'(1)) >= {1'b0, holdoff_cycles};

  always_comb begin
    st_d    = state;
    occ_d   = occ_q;
    fire    = 1'b0;
    tmr_clr = 1'b0;
    tmr_en  = 1'b0;
    if (arm_clr) begin
      st_d    = ST_WAIT_A;
      occ_d   = '0;
      tmr_clr = 1'b1;
    end else begin
      unique case (state)
        ST_WAIT_A: if (ev_a) begin
          occ_d   = '0;
          tmr_clr = 1'b1;
          st_d    = mode_delay ? ST_DELAY : ST_COUNT;
        end
        ST_COUNT: if (ev_b) begin
          if (occ_inc >= n_eff) fire = 1'b1;
          else                  occ_d = occ_inc[CNT_W-1:0];
        end
        ST_DELAY: begin
          tmr_en = ~elapsed;
          if (ev_b && elapsed) fire = 1'b1;
        end
        ST_HOLD: begin
          tmr_en = 1'b1;
          if (hold_done) st_d = ST_WAIT_A;
        end
        default: st_d = ST_WAIT_A;
      endcase
      if (fire) begin
        tmr_clr = 1'b1;
        occ_d   = '0;
        st_d    = (holdoff_cycles == '0) ? ST_WAIT_A : ST_HOLD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_WAIT_A;
      occ_q <= '0;
    end else begin
      state <= st_d;
      occ_q <= occ_d;
    end
  end
endmodule

// File: rtl/seq_trigger.sv
module seq_trigger
  import seq_trig_pkg::*;
#(
  parameter int CNT_W  = 27,
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_clr,
  input  logic              cond_a,
  input  logic              cond_b,
  input  logic              mode_delay,
  input  logic              a_on_exit,
  input  logic              b_on_exit,
  input  logic [CNT_W-1:0]  count_n,
  input  logic [TIME_W-1:0] delay_cycles,
  input  logic [TIME_W-1:0] holdoff_cycles,
  output logic              trig
);
  localparam int NCOND = 2;

  logic              rst_sync_n;
  logic [NCOND-1:0]  cond_v, sel_v, ev_v;
  logic [TIME_W-1:0] span_cnt;
  logic              tmr_clr, tmr_en, fire;
  seq_state_e        seq_state;

  assign cond_v = {cond_b, cond_a};
  assign sel_v  = {b_on_exit, a_on_exit};

  seq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  for (genvar gi = 0; gi < NCOND; gi++) begin : g_edge
    seq_edge_sel u_edge (
      .clk(clk), .rst_n(rst_sync_n), .flag(cond_v[gi]),
      .on_exit(sel_v[gi]), .evt(ev_v[gi])
    );
  end

  seq_span_timer #(.W(TIME_W)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .clr(tmr_clr), .en(tmr_en), .cnt(span_cnt)
  );

  seq_core #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .arm_clr(arm_clr),
    .ev_a(ev_v[0]), .ev_b(ev_v[1]), .mode_delay(mode_delay),
    .count_n(count_n), .delay_cycles(delay_cycles),
    .holdoff_cycles(holdoff_cycles), .tcnt(span_cnt),
    .tmr_clr(tmr_clr), .tmr_en(tmr_en), .fire(fire), .state(seq_state)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) trig <= 1'b0;
    else             trig <= fire;
  end
endmodule

// File: rtl/seq_trigger_chk.sv
module seq_trigger_chk
  import seq_trig_pkg::*;
#(
  parameter int TIME_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm_clr,
  input logic              trig,
  input seq_state_e        state,
  input logic [TIME_W-1:0] tcnt,
  input logic [TIME_W-1:0] delay_cycles
);
  // R5
  trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  // R7
  clr_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_clr |=> (!trig && state == ST_WAIT_A));

  // R3
  idle_no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_A) |=> !trig);

  // R4
  delay_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DELAY && tcnt < delay_cycles) |=> !trig);

  // R6
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |=> !trig);

  // R2
  trig_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> ($past(state) == ST_COUNT || $past(state) == ST_DELAY));
endmodule

bind seq_trigger seq_trigger_chk #(.TIME_W(TIME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm_clr(arm_clr), .trig(trig),
  .state(seq_state), .tcnt(span_cnt), .delay_cycles(delay_cycles)
);

// File: tb/seq_trigger_test.sv
module seq_trigger_test;
  localparam int CNT_W  = 27;
  localparam int TIME_W = 32;
  localparam int NVEC   = 26;
  // row: {arm_clr, cond_a, cond_b, expected trig}; counted, N=3, hold-off 2, enter events
  localparam logic [3:0] VEC [NVEC] = '{
    4'b0000, 4'b0010, 4'b0000, 4'b0100, 4'b0110, 4'b0000, 4'b0110, 4'b0100,
    4'b0111, 4'b0000, 4'b0100, 4'b0110, 4'b0000, 4'b0100, 4'b0010, 4'b0000,
    4'b1010, 4'b0000, 4'b0010, 4'b0100, 4'b0010, 4'b0000, 4'b0010, 4'b0000,
    4'b0011, 4'b0000
  };

  logic clk = 1'b0;
  logic rst_n, arm_clr, cond_a, cond_b, mode_delay, a_on_exit, b_on_exit;
  logic [CNT_W-1:0]  count_n;
  logic [TIME_W-1:0] delay_cycles, holdoff_cycles;
  logic trig;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  seq_trigger #(.CNT_W(CNT_W), .TIME_W(TIME_W)) uut (
    .clk(clk), .rst_n(rst_n), .arm_clr(arm_clr), .cond_a(cond_a),
    .cond_b(cond_b), .mode_delay(mode_delay), .a_on_exit(a_on_exit),
    .b_on_exit(b_on_exit), .count_n(count_n), .delay_cycles(delay_cycles),
    .holdoff_cycles(holdoff_cycles), .trig(trig)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (trig !== exp) begin
      errors++;
      $display("FAIL %s: trig=%b expected %b at %0t", req, trig, exp, $time);
    end
  endtask

  task automatic step(input logic c, input logic a, input logic b,
                      input logic exp, input string req);
    @(negedge clk);
    arm_clr = c; cond_a = a; cond_b = b;
    @(posedge clk);
    #1;
    check(exp, req);
  endtask

  task automatic config_set(input logic md, input logic ax, input logic bx,
                            input int n, input int d, input int h);
    mode_delay = md; a_on_exit = ax; b_on_exit = bx;
    count_n = CNT_W'(n); delay_cycles = TIME_W'(d); holdoff_cycles = TIME_W'(h);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; arm_clr = 1'b0; cond_a = 1'b0; cond_b = 1'b0;
    config_set(1'b0, 1'b0, 1'b0, 3, 0, 2);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(1'b0, "R8 reset");

    // table: R2 count, R3 ignored events, R6 hold-off, R7 clear
    for (int i = 0; i < NVEC; i++)
      step(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], "R2/R3/R6/R7 table");

    // R2: B with A in the same cycle is not counted, N=1
    config_set(1'b0, 1'b0, 1'b0, 1, 0, 0);
    step(0, 0, 0, 0, "R2 prep");
    step(0, 1, 1, 0, "R2 same-cycle B");
    step(0, 1, 0, 0, "R2");
    step(0, 1, 1, 1, "R2 N=1 fire");
    step(0, 1, 0, 0, "R5 single pulse");
    // R2: N=0 acts as 1
    config_set(1'b0, 1'b0, 1'b0, 0, 0, 0);
    step(0, 0, 0, 0, "R2 prep");
    step(0, 1, 0, 0, "R2 A");
    step(0, 1, 1, 1, "R2 N=0 as 1");

    // R4/R9: delayed mode, delay 3
    config_set(1'b1, 1'b0, 1'b0, 5, 3, 0);
    step(0, 0, 0, 0, "R4 prep");
    step(0, 1, 0, 0, "R9 A selects delayed");
    step(0, 1, 1, 0, "R4 k=1 blocked");
    step(0, 1, 0, 0, "R4");
    step(0, 1, 1, 0, "R4 k=3 blocked");
    step(0, 1, 0, 0, "R4");
    step(0, 1, 1, 1, "R4 k=5 fires");
    step(0, 0, 0, 0, "R5 single pulse");

    // R1: exit events on both conditions
    config_set(1'b0, 1'b1, 1'b1, 1, 0, 0);
    step(0, 1, 1, 0, "R1 rise not event");
    step(0, 1, 1, 0, "R1");
    step(0, 0, 1, 0, "R1 A exit");
    step(0, 0, 1, 0, "R1");
    step(0, 0, 0, 1, "R1 B exit fires");

    // R6: hold-off 3, boundaries on both sides
    config_set(1'b0, 1'b0, 1'b0, 1, 0, 3);
    step(0, 0, 0, 0, "R6 prep");
    step(0, 1, 0, 0, "R6 A");
    step(0, 1, 1, 1, "R6 fire");
    step(0, 0, 0, 0, "R6 hold");
    step(0, 0, 0, 0, "R6 hold");
    step(0, 1, 0, 0, "R6 A in last hold cycle");
    step(0, 1, 1, 0, "R6 A was ignored");
    step(0, 0, 0, 0, "R6");
    step(0, 1, 0, 0, "R6 A");
    step(0, 1, 1, 1, "R6 fire");
    step(0, 0, 0, 0, "R6 hold");
    step(0, 0, 0, 0, "R6 hold");
    step(0, 0, 0, 0, "R6 hold");
    step(0, 1, 0, 0, "R6 A first free cycle");
    step(0, 1, 1, 1, "R6 accepted A fires");

    // R2: wide count of 1000
    config_set(1'b0, 1'b0, 1'b0, 1000, 0, 0);
    step(0, 0, 0, 0, "R2 prep");
    step(0, 1, 0, 0, "R2 A");
    for (int k = 1; k <= 1000; k++) begin
      step(0, 0, 1, (k == 1000), "R2 count 1000");
      step(0, 0, 0, 0, "R2 count 1000");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule